// File: doc/BRIEF.md
# Three-Phase Multilevel PWM with Carrier-Band Rotation

This block drives the switch pairs of an N-level clamped inverter with level-shifted carrier PWM. One shared counter produces a triangle that is stacked into N-1 contiguous bands. Each band is offset by one band height. The three phase references are compared against every band, and a gate is high while its reference lies strictly above that band's carrier.

At low modulation index most bands would otherwise stay idle. To avoid this, the block can move the centre of the reference into a sub-region of the carrier stack and step that region once per fundamental cycle. In 2x mode the reference alternates between the upper and lower halves. In 3x mode it steps through the top, middle and bottom thirds. The carrier counter advances by the rotation factor, so the carrier frequency rises by the same factor while each switch pair rests on the cycles its region is not active. Rotation factor and region change only at the fundamental-cycle boundary and are common to all phases, so line-to-line voltages see no step.

Top module: `mlpwm_rotator`

## Requirements
- R1: While reset is low, the phase accumulator and carrier counter are zero, the rate is 1x and the region is 0. With the default 7 levels, `gate_a` is therefore 6'b000111.
- R2: Band k (bit k of each gate bus) has carrier k*BAND + c, where c is the shared triangle value in 0..BAND. A gate bit is 1 exactly when the phase reference is greater than its band carrier, which makes each gate bus a thermometer code from bit 0.
- R3: The shared counter runs modulo 2*BAND and advances by the active rate (1, 2 or 3) each clock. The triangle value is c = q when q < BAND, and 2*BAND - q otherwise.
- R4: A phase reference is centre + floor(m * w * SPAN/2 / 2^17), where SPAN = (LEVELS-1)*BAND and m is the 8-bit index. The waveform w is a 1024-point triangle taken from the top 10 accumulator bits i: w = 2i below 256, 1024-2i below 768, and 2i-2048 otherwise. Phases b and c use i+341 and i+683, each modulo 1024.
- R5: At 1x the centre is SPAN/2.
- R6: At 2x the centre is 3*SPAN/4 in region 1 (upper) and SPAN/4 in region 0 (lower). Entering 2x starts in the upper region, and the region toggles at each following boundary.
- R7: At 3x the centres are 5*SPAN/6, SPAN/2 and SPAN/6 for regions 2, 1 and 0. Entering 3x starts at region 2, and the order is 2, 1, 0, then back to 2.
- R8: The rate and region change only on the clock where the accumulator overflows, and one region value serves all three phases.
- R9: `rot_sel` encodes 2'd3 as 3x and 2'd2 as 2x, while 2'd0 and 2'd1 both mean 1x. A change of `rot_sel` between boundaries has no effect on the gates until the next overflow.
- R10: A reference is clamped to the range 0..SPAN.
- R11: The accumulator adds `freq_word` every clock, modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_idx | input | MW | Modulation index, full scale 256 |
| freq_word | input | FW | Phase increment per clock |
| rot_sel | input | 2 | Requested rotation factor |
| gate_a | output | LEVELS-1 | Phase a switch-pair gates |
| gate_b | output | LEVELS-1 | Phase b switch-pair gates |
| gate_c | output | LEVELS-1 | Phase c switch-pair gates |

## Verification
The bench predicts all three gate buses every cycle under several operating points, each followed for multiple fundamental cycles:
- A large index at 1x shows the centred reference and the full use of the band stack.
- Moderate and small indices at 2x and 3x separate a correct region order and starting region from a wrong one, and show whether the faster carrier step is applied.
- Toggling `rot_sel` inside a cycle shows whether changes are deferred to the boundary.
- A faster frequency word moves the boundaries to new positions.
- A full-scale index at 3x drives the reference outside the stack and exercises the clamp.

// File: rtl/mlpwm_rotator.sv
module mlpwm_rotator #(
  parameter int LEVELS = 7,
  parameter int BAND   = 60,
  parameter int AW     = 20,
  parameter int FW     = 16,
  parameter int MW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MW-1:0]     mod_idx,
  input  logic [FW-1:0]     freq_word,
  input  logic [1:0]        rot_sel,
  output logic [LEVELS-2:0] gate_a,
  output logic [LEVELS-2:0] gate_b,
  output logic [LEVELS-2:0] gate_c
);
  localparam int NB   = LEVELS - 1;
  localparam int SPAN = NB * BAND;
  localparam int HALF = SPAN / 2;
  localparam int PER  = 2 * BAND;
  localparam int CTW  = $clog2(PER + 1);

  logic [AW-1:0]  acc;
  logic [AW:0]    acc_sum;
  logic           wrap;
  logic [CTW-1:0] ctr, ctr_nxt;
  logic [1:0]     rate_q, reg_q, rate_in, reg_nxt;
  logic [9:0]     ia, ib, ic;
  int             car, cen, ref_a, ref_b, ref_c;

  function automatic int tri_w(logic [9:0] i);
    int v;
    v = int'(i);
    if (v < 256)      return 2 * v;
    else if (v < 768) return 1024 - 2 * v;
    else              return 2 * v - 2048;
  endfunction

  function automatic int ref_of(int centre, logic [MW-1:0] m, logic [9:0] i);
    int r;
    r = centre + ((int'(m) * tri_w(i) * HALF) >>> 17);
    if (r < 0) r = 0;
    if (r > SPAN) r = SPAN;
    return r;
  endfunction

  assign acc_sum = {1'b0, acc} + (AW+1)'(freq_word);
  assign wrap    = acc_sum[AW];
  assign rate_in = (rot_sel == 2'd3) ? 2'd3 : (rot_sel == 2'd2) ? 2'd2 : 2'd1;

  always_comb begin
    int ci;
    ci = int'(ctr) + int'(rate_q);
    if (ci >= PER) ci = ci - PER;
    ctr_nxt = CTW'(ci);
  end

  always_comb begin
    if (rate_in != rate_q)  reg_nxt = rate_in - 2'd1;
    else if (reg_q == 2'd0) reg_nxt = rate_q - 2'd1;
    else                    reg_nxt = reg_q - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      ctr    <= '0;
      rate_q <= 2'd1;
      reg_q  <= 2'd0;
    end else begin
      acc <= acc_sum[AW-1:0];
      ctr <= ctr_nxt;
      if (wrap) begin
        rate_q <= rate_in;
        reg_q  <= reg_nxt;
      end
    end
  end

  assign car = (int'(ctr) < BAND) ? int'(ctr) : PER - int'(ctr);

  always_comb begin
    case ({rate_q, reg_q})
      4'b10_01: cen = (SPAN * 3) / 4;
      4'b10_00: cen = SPAN / 4;
      4'b11_10: cen = (SPAN * 5) / 6;
      4'b11_00: cen = SPAN / 6;
      default:  cen = HALF;
    endcase
  end

  assign ia = acc[AW-1 -: 10];
  assign ib = ia + 10'd341;
  assign ic = ia + 10'd683;
  assign ref_a = ref_of(cen, mod_idx, ia);
  assign ref_b = ref_of(cen, mod_idx, ib);
  assign ref_c = ref_of(cen, mod_idx, ic);

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      gate_a[k] = ref_a > (k * BAND + car);
      gate_b[k] = ref_b > (k * BAND + car);
      gate_c[k] = ref_c > (k * BAND + car);
    end
  end
endmodule

module mlpwm_rotator_chk #(
  parameter int LEVELS = 7,
  parameter int BAND   = 60,
  parameter int CTW    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrap,
  input logic [CTW-1:0]    ctr,
  input logic [1:0]        rate_q,
  input logic [1:0]        reg_q,
  input logic [LEVELS-2:0] gate_a,
  input logic [LEVELS-2:0] gate_b,
  input logic [LEVELS-2:0] gate_c
);
  a_r8_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(rate_q) && $stable(reg_q)));
  a_r7_region_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q < rate_q);
  a_r3_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ctr) < 2 * BAND);
  a_r7_region_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'd3 && $past(rate_q) == 2'd3 && reg_q != $past(reg_q))
      |-> (reg_q == (($past(reg_q) == 2'd0) ? 2'd2 : $past(reg_q) - 2'd1)));
  a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_a & (gate_a + 1'b1)) == '0) && ((gate_b & (gate_b + 1'b1)) == '0)
      && ((gate_c & (gate_c + 1'b1)) == '0));
endmodule

bind mlpwm_rotator mlpwm_rotator_chk #(.LEVELS(LEVELS), .BAND(BAND), .CTW(CTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .ctr(ctr), .rate_q(rate_q), .reg_q(reg_q),
  .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
);

// File: tb/sim_mlpwm_rotator.sv
module sim_mlpwm_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 7, BAND = 60, AW = 20, FW = 16, MW = 8;
  localparam int NB = LEVELS - 1, SPAN = NB * BAND, HALF = SPAN / 2, PER = 2 * BAND;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MW-1:0] mod_idx = 8'd128;
  logic [FW-1:0] freq_word = 16'd256;
  logic [1:0] rot_sel = 2'd1;
  logic [NB-1:0] gate_a, gate_b, gate_c;

  typedef struct { logic [NB-1:0] a, b, c; string tag; } exp_t;
  exp_t sbq[$];
  string cur_tag = "R1";
  int total = 0, bad = 0;
  int m_acc, m_ctr, m_rate, m_reg, sum, nr, idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlpwm_rotator #(.LEVELS(LEVELS), .BAND(BAND), .AW(AW), .FW(FW), .MW(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_idx(mod_idx), .freq_word(freq_word),
    .rot_sel(rot_sel), .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c));

  function automatic int tri_w(int i);
    if (i < 256) return 2 * i;
    else if (i < 768) return 1024 - 2 * i;
    else return 2 * i - 2048;
  endfunction

  function automatic int centre(int rate, int rg);
    if (rate == 2) return (rg == 1) ? SPAN * 3 / 4 : SPAN / 4;
    if (rate == 3) return (rg == 2) ? SPAN * 5 / 6 : (rg == 1) ? HALF : SPAN / 6;
    return HALF;
  endfunction

  function automatic logic [NB-1:0] gates(int i, int m, int rate, int rg, int q);
    logic [NB-1:0] g;
    int c, r;
    c = (q < BAND) ? q : PER - q;
    r = centre(rate, rg) + ((m * tri_w(i) * HALF) >>> 17);
    if (r < 0) r = 0;
    if (r > SPAN) r = SPAN;
    for (int k = 0; k < NB; k++) g[k] = r > (k * BAND + c);
    return g;
  endfunction

  // predictor: model state follows each edge, expected item pushed once inputs settle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_ctr = 0; m_rate = 1; m_reg = 0;
    end else begin
      sum = m_acc + int'(freq_word);
      nr = (rot_sel == 2'd3) ? 3 : (rot_sel == 2'd2) ? 2 : 1;
      m_ctr = (m_ctr + m_rate) % PER;
      if (sum >= (1 << AW)) begin
        if (nr != m_rate) m_reg = nr - 1;
        else m_reg = (m_reg == 0) ? m_rate - 1 : m_reg - 1;
        m_rate = nr;
      end
      m_acc = sum % (1 << AW);
    end
    #4;
    idx = m_acc >> (AW - 10);
    sbq.push_back('{gates(idx, int'(mod_idx), m_rate, m_reg, m_ctr),
                    gates((idx + 341) % 1024, int'(mod_idx), m_rate, m_reg, m_ctr),
                    gates((idx + 683) % 1024, int'(mod_idx), m_rate, m_reg, m_ctr),
                    cur_tag});
  end

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      total++;
      if (gate_a !== e.a || gate_b !== e.b || gate_c !== e.c) begin
        bad++;
        if (bad < 20)
          $display("FAIL %s t=%0t actual a=%b b=%b c=%b expected a=%b b=%b c=%b",
                   e.tag, $time, gate_a, gate_b, gate_c, e.a, e.b, e.c);
      end
    end
  end

  task automatic drive(int n, int m, int fw, int rs, string tag);
    @(posedge clk); #2;
    mod_idx = MW'(m); freq_word = FW'(fw); rot_sel = 2'(rs); cur_tag = tag;
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (gate_a !== 6'b000111) begin
      bad++;
      $display("FAIL R1 reset gate_a actual %b expected %b", gate_a, 6'b000111);
    end
    @(posedge clk); #2; rst_n = 1'b1;
    drive(8300, 200, 256, 1, "R5");        // 1x, centred, large index
    drive(12400, 100, 256, 2, "R6");       // 2x, upper then lower halves
    drive(16500, 60, 256, 3, "R7");        // 3x, top/middle/bottom order
    drive(6000, 90, 256, 0, "R9");         // 1x via code 0
    drive(1000, 90, 256, 2, "R9");         // mid-cycle request, deferred
    drive(1000, 90, 256, 0, "R9");
    drive(3300, 80, 1000, 2, "R11");       // faster accumulator
    drive(4300, 255, 1000, 3, "R10");      // reference driven outside stack
    drive(2000, 0, 256, 1, "R4");          // zero index: flat reference
    drive(2, 0, 256, 1, "R2");
    finish_run();
  end
endmodule